// File: doc/BRIEF.md
# Indirect Address Pattern Learner

This block finds the linear rule behind an indirect access stream of the form `A[B[i]]`. A streaming index array `B` is read in order, and shortly afterwards the program touches `A` at an address equal to `coeff * B[i] + base`. The learner watches the index values as they are read and the cache misses that follow them. For every candidate coefficient it works out what base address each miss would imply. Once two index reads of the same stream produce the same implied base for the same coefficient, the learner has the rule and hands it to a prefetch table as a single write command.

Each of a small set of tracking slots follows one index stream, named by a stream id. The first index read of a stream claims a slot. Up to four misses after that read each store one implied base per coefficient. The second index read switches the slot to matching mode, and each miss after it is tested against the stored bases. The candidate coefficients are 4, 8, 16 and 1/8, so every product is a shift. All slots see every miss. Cache hits do not count as events.

Top module: `ipd_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `wr_vld` is low and every slot is free.
- R2: An index read whose stream id no busy slot holds claims the lowest-numbered free slot. When all slots are busy the read is dropped. A stream id is held by at most one slot.
- R3: Coefficient codes are 0 = ×4, 1 = ×8, 2 = ×16 and 3 = ÷8 (a right shift by 3 that drops the low bits). After the first index read, each of the next four misses stores `miss_addr − coeff·index` for every code, with arithmetic modulo 2^ADDR_W.
- R4: A second index read of the same stream puts its slot into matching mode. Each later miss computes `miss_addr − coeff·index2` per code and compares it with the stored bases of the same code. On a hit, `wr_vld` is high for one cycle, the cycle after the miss, carrying the stream id, the code and the base, and the slot becomes free.
- R5: Index 1, then a miss at 0x100, then index 16, then a miss at 0x13C gives a report with code 0 and base 0xFC.
- R6: An access with `acc_hit` high changes nothing. An access presented in the same cycle as an index read is ignored, and the index read is processed.
- R7: A fifth miss after the first index read, with no second read in between, frees the slot. A fifth unmatched miss in matching mode also frees the slot. A fourth unmatched miss does not.
- R8: A third index read of a stream in matching mode restarts learning, and that value becomes the new first index. The stored bases are discarded.
- R9: When several codes match on one miss, the reported code is chosen in the order 3, 0, 1, 2, so the smallest coefficient wins.
- R10: When several slots match on one miss, only the lowest-numbered one reports and is freed. The others count that miss as unmatched.
- R11: Every busy slot processes every miss independently of its stream id.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_vld | input | 1 | An index value was read this cycle |
| idx_val | input | IDX_W | Index value read |
| idx_sid | input | SID_W | Stream id of the index read |
| acc_vld | input | 1 | A data cache access this cycle |
| acc_hit | input | 1 | The access hit in the cache |
| acc_addr | input | ADDR_W | Address of the access |
| wr_vld | output | 1 | Learned pattern write command |
| wr_sid | output | SID_W | Stream id of the learned pattern |
| wr_coef | output | 2 | Coefficient code (see R3) |
| wr_base | output | ADDR_W | Learned base address |

## Verification
Every event takes effect at the rising edge that samples it. Slot state changes at that edge, so the next cycle's event already sees the new state. A report appears on the `wr_*` outputs right after the edge that sampled the matching miss, and it stays for exactly that one cycle. The bench's queue-based model advances at the same rising edge, and the outputs are compared with it at every falling edge, half a cycle after they settle. The directed checks on report counts and fields are made after two idle cycles, so the expected report has already been captured when they run.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
  localparam int NCOEF = 4;

  typedef enum logic [1:0] {
    C_X4   = 2'd0,
    C_X8   = 2'd1,
    C_X16  = 2'd2,
    C_DIV8 = 2'd3
  } coef_t;

  typedef enum logic [1:0] {
    PH_FREE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  // selection order when several codes hit: smallest coefficient first
  localparam coef_t PRIO [NCOEF] = '{C_DIV8, C_X4, C_X8, C_X16};
endpackage

// File: rtl/ipd_pick.sv
module ipd_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  assign gnt = req & ~(req - N'(1));
  assign any = |req;
endmodule

// File: rtl/ipd_entry.sv
module ipd_entry
  import ipd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 32,
  parameter int SID_W  = 4,
  parameter int SLOTS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_alloc,
  input  logic              idx_take,
  input  logic [IDX_W-1:0]  idx_val,
  input  logic [SID_W-1:0]  idx_sid,
  input  logic              miss,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              grant,
  output logic              busy,
  output logic [SID_W-1:0]  sid,
  output logic              match,
  output logic [1:0]        m_coef,
  output logic [ADDR_W-1:0] m_base
);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOTS);

  function automatic logic [ADDR_W-1:0] scale(input int c, input logic [ADDR_W-1:0] v);
    case (c)
      0:       return v << 2;
      1:       return v << 3;
      2:       return v << 4;
      default: return v >> 3;
    endcase
  endfunction

  phase_e            st_q;
  logic [SID_W-1:0]  sid_q;
  logic [ADDR_W-1:0] idx_q;
  logic [CNT_W-1:0]  nst_q, cnt_q;
  logic [ADDR_W-1:0] base_q [NCOEF][SLOTS];
  logic [ADDR_W-1:0] cand [NCOEF];
  logic [NCOEF-1:0]  hitc;
  logic [ADDR_W-1:0] idx_a;
  logic              full, wr_slot;
  coef_t             pick;

  assign idx_a = ADDR_W'(idx_val);
  assign full  = (nst_q == CNT_MAX);
  assign busy  = (st_q != PH_FREE);
  assign sid   = sid_q;

  // implied bases for the current miss and comparison against stored ones
  always_comb begin
    for (int c = 0; c < NCOEF; c++) begin
      cand[c] = miss_addr - scale(c, idx_q);
      hitc[c] = 1'b0;
      for (int k = 0; k < SLOTS; k++)
        if ((k < int'(nst_q)) && (base_q[c][k] == cand[c])) hitc[c] = 1'b1;
    end
  end

  always_comb begin
    pick = PRIO[0];
    for (int p = NCOEF - 1; p >= 0; p--)
      if (hitc[PRIO[p]]) pick = PRIO[p];
  end

  assign match  = miss && (st_q == PH_SECOND) && (|hitc);
  assign m_coef = pick;
  assign m_base = cand[pick];

  assign wr_slot = miss && !idx_alloc && !idx_take && (st_q == PH_FIRST) && !full;

  // base storage: no reset, write-only at one slot per cycle
  always_ff @(posedge clk) begin
    if (wr_slot)
      for (int c = 0; c < NCOEF; c++)
        for (int k = 0; k < SLOTS; k++)
          if (k == int'(nst_q)) base_q[c][k] <= cand[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PH_FREE;
      sid_q <= '0;
      idx_q <= '0;
      nst_q <= '0;
      cnt_q <= '0;
    end else if (idx_alloc) begin
      st_q  <= PH_FIRST;
      sid_q <= idx_sid;
      idx_q <= idx_a;
      nst_q <= '0;
      cnt_q <= '0;
    end else if (idx_take) begin
      idx_q <= idx_a;
      cnt_q <= '0;
      if (st_q == PH_FIRST) begin
        st_q <= PH_SECOND;
      end else begin
        st_q  <= PH_FIRST;
        nst_q <= '0;
      end
    end else if (miss) begin
      case (st_q)
        PH_FIRST: begin
          if (full) st_q <= PH_FREE;
          else      nst_q <= nst_q + CNT_W'(1);
        end
        PH_SECOND: begin
          if (match && grant)      st_q <= PH_FREE;
          else if (cnt_q == CNT_MAX) st_q <= PH_FREE;
          else                     cnt_q <= cnt_q + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  // R7
  slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (nst_q <= CNT_MAX) && (cnt_q <= CNT_MAX));

  // R10
  grant_match_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> match);

  // R4
  free_after_report_chk: assert property (@(posedge clk) disable iff (rst)
    (match && grant) |=> !busy);
endmodule

// File: rtl/ipd_top.sv
module ipd_top
  import ipd_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 32,
  parameter int SID_W  = 4,
  parameter int SLOTS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_vld,
  input  logic [IDX_W-1:0]  idx_val,
  input  logic [SID_W-1:0]  idx_sid,
  input  logic              acc_vld,
  input  logic              acc_hit,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              wr_vld,
  output logic [SID_W-1:0]  wr_sid,
  output logic [1:0]        wr_coef,
  output logic [ADDR_W-1:0] wr_base
);
  logic [N_ENT-1:0]  busy_v, own_v, free_gnt, alloc_v, take_v, match_v, gnt_v;
  logic              any_own, any_free, any_match, miss_eff;
  logic [SID_W-1:0]  e_sid  [N_ENT];
  logic [1:0]        e_coef [N_ENT];
  logic [ADDR_W-1:0] e_base [N_ENT];
  logic [SID_W-1:0]  sel_sid;
  logic [1:0]        sel_coef;
  logic [ADDR_W-1:0] sel_base;

  assign miss_eff = acc_vld && !acc_hit && !idx_vld;

  always_comb begin
    for (int e = 0; e < N_ENT; e++)
      own_v[e] = busy_v[e] && (e_sid[e] == idx_sid);
  end
  assign any_own = |own_v;

  ipd_pick #(.N(N_ENT)) i_free_pick (.req(~busy_v), .gnt(free_gnt), .any(any_free));
  ipd_pick #(.N(N_ENT)) i_match_pick (.req(match_v), .gnt(gnt_v), .any(any_match));

  assign alloc_v = (idx_vld && !any_own && any_free) ? free_gnt : '0;
  assign take_v  = idx_vld ? own_v : '0;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    ipd_entry #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SID_W(SID_W), .SLOTS(SLOTS)
    ) i_ent (
      .clk      (clk),
      .rst      (rst),
      .idx_alloc(alloc_v[e]),
      .idx_take (take_v[e]),
      .idx_val  (idx_val),
      .idx_sid  (idx_sid),
      .miss     (miss_eff),
      .miss_addr(acc_addr),
      .grant    (gnt_v[e]),
      .busy     (busy_v[e]),
      .sid      (e_sid[e]),
      .match    (match_v[e]),
      .m_coef   (e_coef[e]),
      .m_base   (e_base[e])
    );
  end

  always_comb begin
    sel_sid  = '0;
    sel_coef = '0;
    sel_base = '0;
    for (int e = 0; e < N_ENT; e++)
      if (gnt_v[e]) begin
        sel_sid  = e_sid[e];
        sel_coef = e_coef[e];
        sel_base = e_base[e];
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_vld  <= 1'b0;
      wr_sid  <= '0;
      wr_coef <= '0;
      wr_base <= '0;
    end else begin
      wr_vld <= any_match;
      if (any_match) begin
        wr_sid  <= sel_sid;
        wr_coef <= sel_coef;
        wr_base <= sel_base;
      end
    end
  end

  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(own_v));

  // R2
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc_v | take_v));

  // R4
  report_after_miss_chk: assert property (@(posedge clk) disable iff (rst)
    any_match |=> wr_vld);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!idx_vld && !(acc_vld && !acc_hit)) |=> ($stable(busy_v) && !wr_vld));
endmodule

// File: tb/test_ipd_top.sv
`timescale 1ns/1ps
module test_ipd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        idx_vld = 1'b0;
  logic [31:0] idx_val = '0;
  logic [3:0]  idx_sid = '0;
  logic        acc_vld = 1'b0;
  logic        acc_hit = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        wr_vld;
  logic [3:0]  wr_sid;
  logic [1:0]  wr_coef;
  logic [31:0] wr_base;

  always #10 clk = ~clk;

  ipd_top i_ipd_top (
    .clk(clk), .rst(rst), .idx_vld(idx_vld), .idx_val(idx_val), .idx_sid(idx_sid),
    .acc_vld(acc_vld), .acc_hit(acc_hit), .acc_addr(acc_addr),
    .wr_vld(wr_vld), .wr_sid(wr_sid), .wr_coef(wr_coef), .wr_base(wr_base)
  );

  int    vec = 0, fail = 0, nrep = 0, cycles = 0;
  bit    done = 0;
  string cur_req = "R1";
  logic [3:0]  l_sid;
  logic [1:0]  l_coef;
  logic [31:0] l_base;

  // ---------------- behavioural reference model ----------------
  int          m_st  [4];
  logic [3:0]  m_sid [4];
  logic [31:0] m_idx [4];
  int          m_cnt [4];
  logic [31:0] m_b   [4][4][$];
  int          ord   [4] = '{3, 0, 1, 2};
  logic        exp_vld = 0;
  logic [3:0]  exp_sid = '0;
  logic [1:0]  exp_coef = '0;
  logic [31:0] exp_base = '0;

  function automatic logic [31:0] mul(int c, logic [31:0] v);
    case (c)
      0: return v * 4;
      1: return v * 8;
      2: return v * 16;
      default: return v / 8;
    endcase
  endfunction

  always @(posedge clk) begin
    int own, fr, fc;
    bit won;
    logic [31:0] fb, cd;
    exp_vld = 0;
    if (rst) begin
      for (int e = 0; e < 4; e++) m_st[e] = 0;
    end else if (idx_vld) begin
      own = -1;
      for (int e = 0; e < 4; e++) if (m_st[e] != 0 && m_sid[e] == idx_sid) own = e;
      if (own >= 0) begin
        m_idx[own] = idx_val;
        m_cnt[own] = 0;
        if (m_st[own] == 1) m_st[own] = 2;
        else begin
          m_st[own] = 1;
          for (int c = 0; c < 4; c++) m_b[own][c].delete();
        end
      end else begin
        fr = -1;
        for (int e = 3; e >= 0; e--) if (m_st[e] == 0) fr = e;
        if (fr >= 0) begin
          m_st[fr] = 1; m_sid[fr] = idx_sid; m_idx[fr] = idx_val; m_cnt[fr] = 0;
          for (int c = 0; c < 4; c++) m_b[fr][c].delete();
        end
      end
    end else if (acc_vld && !acc_hit) begin
      won = 0;
      for (int e = 0; e < 4; e++) begin
        if (m_st[e] == 1) begin
          if (m_b[e][0].size() == 4) m_st[e] = 0;
          else for (int c = 0; c < 4; c++) m_b[e][c].push_back(acc_addr - mul(c, m_idx[e]));
        end else if (m_st[e] == 2) begin
          fc = -1; fb = '0;
          for (int p = 0; p < 4; p++) begin
            cd = acc_addr - mul(ord[p], m_idx[e]);
            if (fc < 0)
              foreach (m_b[e][ord[p]][j]) if (m_b[e][ord[p]][j] == cd) begin fc = ord[p]; fb = cd; end
          end
          if (fc >= 0 && !won) begin
            exp_vld = 1; exp_sid = m_sid[e]; exp_coef = 2'(fc); exp_base = fb;
            won = 1; m_st[e] = 0;
          end else if (m_cnt[e] == 4) m_st[e] = 0;
          else m_cnt[e]++;
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst && !done) begin
      vec++;
      if (wr_vld !== exp_vld || (exp_vld && (wr_sid !== exp_sid || wr_coef !== exp_coef || wr_base !== exp_base))) begin
        fail++;
        $display("FAIL %s: actual vld=%0b sid=%0d coef=%0d base=%h, expected vld=%0b sid=%0d coef=%0d base=%h",
                 cur_req, wr_vld, wr_sid, wr_coef, wr_base, exp_vld, exp_sid, exp_coef, exp_base);
      end
      if (wr_vld) begin nrep++; l_sid = wr_sid; l_coef = wr_coef; l_base = wr_base; end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !done) begin
      done = 1;
      fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 60000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit iv, logic [31:0] v, logic [3:0] s, bit av, bit ah, logic [31:0] a);
    @(negedge clk);
    idx_vld = iv; idx_val = v; idx_sid = s; acc_vld = av; acc_hit = ah; acc_addr = a;
  endtask
  task automatic rd(logic [31:0] v, logic [3:0] s); cyc(1, v, s, 0, 0, 0); endtask
  task automatic miss(logic [31:0] a); cyc(0, 0, 0, 1, 0, a); endtask
  task automatic idle(int n); repeat (n) cyc(0, 0, 0, 0, 0, 0); endtask
  task automatic do_reset();
    cyc(0, 0, 0, 0, 0, 0);
    rst = 1;
    idle(2);
    rst = 0;
    idle(1);
  endtask

  initial begin
    int r0;
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(wr_vld == 0, "R1", wr_vld, 0);
    end
    rst = 0;
    idle(2);
    chk(wr_vld == 0 && nrep == 0, "R1", nrep, 0);

    // R5 / R3 / R4: worked example
    cur_req = "R5";
    r0 = nrep;
    rd(1, 2); miss(32'h100); rd(16, 2); miss(32'h13C); idle(2);
    chk(nrep == r0 + 1 && l_coef == 0 && l_base == 32'hFC && l_sid == 2, "R5", l_base, 32'hFC);

    // R4: code 2 learned
    cur_req = "R4";
    do_reset(); r0 = nrep;
    rd(2, 9); miss(32'h1020); rd(5, 9); miss(32'h1050); idle(2);
    chk(nrep == r0 + 1 && l_coef == 2 && l_base == 32'h1000, "R4", l_coef, 2);

    // R3: modular arithmetic
    cur_req = "R3";
    do_reset(); r0 = nrep;
    rd(32'h4000_0000, 1); miss(32'h10); rd(0, 1); miss(32'h10); idle(2);
    chk(nrep == r0 + 1 && l_coef == 0 && l_base == 32'h10, "R3", l_base, 32'h10);

    // R6: hits and same-cycle accesses ignored
    cur_req = "R6";
    do_reset(); r0 = nrep;
    rd(1, 3); cyc(0, 0, 0, 1, 1, 32'h100); rd(16, 3); cyc(0, 0, 0, 1, 1, 32'h13C); idle(2);
    chk(nrep == r0, "R6", nrep - r0, 0);
    do_reset(); r0 = nrep;
    cyc(1, 1, 3, 1, 0, 32'h100); rd(16, 3); miss(32'h13C); idle(2);
    chk(nrep == r0, "R6", nrep - r0, 0);

    // R7: overflow limits
    cur_req = "R7";
    do_reset(); r0 = nrep;
    rd(1, 4); miss(32'h100); miss(32'h200); miss(32'h300); miss(32'h400); miss(32'h500);
    rd(16, 4); miss(32'h13C); idle(2);
    chk(nrep == r0, "R7", nrep - r0, 0);
    do_reset(); r0 = nrep;
    rd(1, 4); miss(32'h100); rd(16, 4);
    for (int i = 0; i < 4; i++) miss(32'h5000 + i * 32'h100);
    miss(32'h13C); idle(2);
    chk(nrep == r0 + 1 && l_base == 32'hFC, "R7", nrep - r0, 1);
    do_reset(); r0 = nrep;
    rd(1, 4); miss(32'h100); rd(16, 4);
    for (int i = 0; i < 5; i++) miss(32'h5000 + i * 32'h100);
    miss(32'h13C); idle(2);
    chk(nrep == r0, "R7", nrep - r0, 0);

    // R8: third index read restarts learning
    cur_req = "R8";
    do_reset(); r0 = nrep;
    rd(1, 6); miss(32'h100); rd(16, 6); rd(2, 6); miss(32'h108); rd(3, 6); miss(32'h10C); idle(2);
    chk(nrep == r0 + 1 && l_coef == 0 && l_base == 32'h100, "R8", l_base, 32'h100);

    // R9: coefficient priority
    cur_req = "R9";
    do_reset(); r0 = nrep;
    rd(0, 7); miss(32'h400); rd(0, 7); miss(32'h400); idle(2);
    chk(nrep == r0 + 1 && l_coef == 3 && l_base == 32'h400, "R9", l_coef, 3);
    do_reset(); r0 = nrep;
    rd(0, 7); miss(32'hFC0); miss(32'hFE0); rd(8, 7); miss(32'h1000); idle(2);
    chk(nrep == r0 + 1 && l_coef == 0 && l_base == 32'hFE0, "R9", l_coef, 0);

    // R2 / R10 / R11: full table, shared misses
    cur_req = "R10";
    do_reset(); r0 = nrep;
    for (int s = 1; s <= 5; s++) rd(0, 4'(s));
    miss(32'h800);
    for (int s = 1; s <= 5; s++) rd(0, 4'(s));
    repeat (5) miss(32'h800);
    idle(2);
    chk(nrep == r0 + 4, "R2", nrep - r0, 4);
    chk(l_sid == 4, "R10", l_sid, 4);

    // R11: random mix against the model
    cur_req = "R11";
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom % 10;
      if (k < 2) rd($urandom % 8, 4'($urandom % 6));
      else if (k < 8) cyc(0, 0, 0, 1, ($urandom % 4) == 0, 32'h100 + ($urandom % 16) * 4);
      else if (k < 9) cyc(1, $urandom % 8, 4'($urandom % 6), 1, 0, 32'h100 + ($urandom % 16) * 4);
      else idle(1);
    end
    idle(3);
    chk(nrep > r0, "R11", nrep, r0);

    done = 1;
    summary();
    $finish;
  end
endmodule